// File: doc/BRIEF.md
# Quadword Memory-to-Stream DMA Channel

A single transfer engine that software sets up through a narrow write-only configuration port. It takes a source byte address and a quadword count. Once it is started, it fetches that many 128-bit words from memory, one read at a time, and delivers them in order on a valid/ready stream with an end-of-transfer marker on the final word.

The channel has one memory read outstanding at most. It waits for the read data, registers it, and holds the word on the stream until the sink takes it. A sink that drops ready partway through a burst freezes the channel on the current word, and the channel resumes at the correct address. Each word the sink accepts produces an event pulse that carries the word's index and source address. When the last word has been accepted, a one-cycle done event and a one-cycle interrupt fire together. The run flag that the start command set then clears.

Top module: `qw_stream_dma`

## Requirements
- R1: While reset is held, ep_valid, mem_rd_en, beat_ev, done_ev, irq_done and chan_busy are all 0.
- R2: A configuration write to offset 0x10 loads the source address. A write to 0x20 loads the quadword count from the low bits of the data. A write to 0x00 with data bit 0 set starts a transfer. A write to 0x00 with bit 0 clear starts nothing.
- R3: The channel issues exactly one memory read per quadword and never has a second read outstanding. The read for quadword n uses address source + 16·n (modulo 2^ADDR_W), and it is issued only after quadword n−1 has been accepted.
- R4: ep_valid rises only in the cycle after mem_rd_valid, and ep_data equals the word returned for that read.
- R5: While ep_valid is 1 and ep_ready is 0, the next cycle keeps ep_valid at 1 with ep_data and ep_last unchanged. No quadword is skipped or repeated across a stall.
- R6: ep_last is 1 exactly on the quadword with index count−1.
- R7: beat_ev pulses in exactly the cycles where ep_valid and ep_ready are both 1. beat_ev_idx then gives the quadword index and beat_ev_addr gives its source address.
- R8: done_ev and irq_done pulse together for one cycle, in the cycle after the final quadword is accepted. They never fire before all quadwords have been accepted, including while the sink stalls.
- R9: chan_busy rises with the start command and falls the cycle after done_ev. Every configuration write made while chan_busy is 1 is ignored, so a later start repeats the earlier programming.
- R10: A start with a count of zero raises done_ev in the following cycle, with no memory read and no stream word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_offset | input | 8 | Configuration register offset |
| cfg_wr_data | input | CFG_W | Configuration write data |
| mem_rd_en | output | 1 | Memory read request, one cycle per quadword |
| mem_rd_addr | output | ADDR_W | Byte address of the requested quadword |
| mem_rd_data | input | DATA_W | Read data |
| mem_rd_valid | input | 1 | Read data valid |
| ep_valid | output | 1 | Stream word valid |
| ep_data | output | DATA_W | Stream word |
| ep_last | output | 1 | Final word of the transfer |
| ep_ready | input | 1 | Sink accepts the word |
| beat_ev | output | 1 | Accepted-word event |
| beat_ev_idx | output | CNT_W | Index of the accepted word |
| beat_ev_addr | output | ADDR_W | Source address of the accepted word |
| done_ev | output | 1 | Transfer-complete event |
| irq_done | output | 1 | Completion interrupt pulse |
| chan_busy | output | 1 | Run flag, set by start and cleared on completion |

## Verification
The bench builds the channel with its default parameters: a 32-bit address, 128-bit words and a 16-bit count. This puts the address wrap at the top of the 32-bit space within reach, and one table vector crosses that wrap. Read latencies from one to five cycles and several ready patterns exercise stalls in every position within a burst. Directed tests cover a long stall after two accepted words, a zero count, a start command with the bit clear, and writes made during a transfer.

// File: rtl/qsd_pkg.sv
package qsd_pkg;

  // Register offsets; the channel decodes these exact values.
  localparam logic [7:0] REG_CTRL = 8'h00;
  localparam logic [7:0] REG_SRC  = 8'h10;
  localparam logic [7:0] REG_LEN  = 8'h20;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT,
    ST_SEND,
    ST_DONE
  } qsd_state_e;

  // Byte address of quadword idx, given the log2 of the quadword size.
  function automatic logic [63:0] qw_addr(input logic [63:0] base,
                                          input logic [63:0] idx,
                                          input int unsigned shift);
    return base + (idx << shift);
  endfunction

  // True when idx is the final index of a transfer of cnt quadwords.
  function automatic logic is_final(input logic [31:0] idx,
                                    input logic [31:0] cnt);
    return (cnt != 32'd0) && (idx == cnt - 32'd1);
  endfunction

endpackage

// File: rtl/qsd_regs.sv
module qsd_regs #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int CFG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_offset,
  input  logic [CFG_W-1:0]  wr_data,
  input  logic              finish_i,
  output logic [ADDR_W-1:0] src_o,
  output logic [CNT_W-1:0]  len_o,
  output logic              start_o,
  output logic              run_o
);
  import qsd_pkg::*;

  logic [ADDR_W-1:0] src_q;
  logic [CNT_W-1:0]  len_q;
  logic              run_q;
  logic              wr_ok;

  // Writes only land while the channel is idle.
  assign wr_ok   = wr_en && !run_q;
  assign start_o = wr_ok && (wr_offset == REG_CTRL) && wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      len_q <= '0;
    end else if (wr_ok) begin
      case (wr_offset)
        REG_SRC: src_q <= ADDR_W'(wr_data);
        REG_LEN: len_q <= CNT_W'(wr_data);
        default: ;
      endcase
    end
  end

  // Run flag: set by the start command, cleared when the transfer ends.
  always_ff @(posedge clk) begin
    if (!rst_n)        run_q <= 1'b0;
    else if (start_o)  run_q <= 1'b1;
    else if (finish_i) run_q <= 1'b0;
  end

  assign src_o = src_q;
  assign len_o = len_q;
  assign run_o = run_q;

endmodule

// File: rtl/qsd_beat_ctr.sv
module qsd_beat_ctr #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int BEAT_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [CNT_W-1:0]  len_i,
  output logic [CNT_W-1:0]  idx_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o,
  output logic              empty_o
);
  import qsd_pkg::*;

  logic [CNT_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      idx_q <= '0;
    else if (load_i) idx_q <= '0;
    else if (step_i) idx_q <= idx_q + 1'b1;
  end

  // The source register is frozen while running, so the address is derived
  // from it and the index instead of a second running accumulator.
  assign addr_o  = ADDR_W'(qw_addr(64'(src_i), 64'(idx_q), BEAT_SHIFT));
  assign last_o  = is_final(32'(idx_q), 32'(len_i));
  assign empty_o = (len_i == '0);
  assign idx_o   = idx_q;

endmodule

// File: rtl/qsd_fsm.sv
module qsd_fsm #(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              empty_i,
  input  logic              last_i,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              snk_ready_i,
  output logic              rd_req_o,
  output logic              snk_valid_o,
  output logic [DATA_W-1:0] snk_data_o,
  output logic              accept_o,
  output logic              finish_o
);
  import qsd_pkg::*;

  qsd_state_e state_q, state_d;
  logic [DATA_W-1:0] word_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_i) state_d = empty_i ? ST_DONE : ST_READ;
      ST_READ: state_d = ST_WAIT;
      ST_WAIT: if (rd_valid_i) state_d = ST_SEND;
      ST_SEND: if (snk_ready_i) state_d = last_i ? ST_DONE : ST_READ;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // Word register: loaded only when read data arrives, so it stays put for
  // the whole time the word is offered on the stream.
  always_ff @(posedge clk) begin
    if (!rst_n)                              word_q <= '0;
    else if (state_q == ST_WAIT && rd_valid_i) word_q <= rd_data_i;
  end

  assign rd_req_o    = (state_q == ST_READ);
  assign snk_valid_o = (state_q == ST_SEND);
  assign snk_data_o  = word_q;
  assign accept_o    = (state_q == ST_SEND) && snk_ready_i;
  assign finish_o    = (state_q == ST_DONE);

endmodule

// File: rtl/qw_stream_dma.sv
module qw_stream_dma #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 128,
  parameter int CFG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [7:0]        cfg_offset,
  input  logic [CFG_W-1:0]  cfg_wr_data,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  input  logic              mem_rd_valid,
  output logic              ep_valid,
  output logic [DATA_W-1:0] ep_data,
  output logic              ep_last,
  input  logic              ep_ready,
  output logic              beat_ev,
  output logic [CNT_W-1:0]  beat_ev_idx,
  output logic [ADDR_W-1:0] beat_ev_addr,
  output logic              done_ev,
  output logic              irq_done,
  output logic              chan_busy
);
  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int BEAT_SHIFT = $clog2(BEAT_BYTES);

  // Named internal events between the pieces.
  logic              start_w;
  logic              accept_w;
  logic              finish_w;
  logic              run_w;
  logic              last_w;
  logic              empty_w;
  logic [ADDR_W-1:0] src_w;
  logic [CNT_W-1:0]  len_w;
  logic [CNT_W-1:0]  idx_w;
  logic [ADDR_W-1:0] addr_w;

  qsd_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CFG_W(CFG_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr_en),
    .wr_offset(cfg_offset),
    .wr_data  (cfg_wr_data),
    .finish_i (finish_w),
    .src_o    (src_w),
    .len_o    (len_w),
    .start_o  (start_w),
    .run_o    (run_w)
  );

  qsd_beat_ctr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BEAT_SHIFT(BEAT_SHIFT)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (start_w),
    .step_i (accept_w),
    .src_i  (src_w),
    .len_i  (len_w),
    .idx_o  (idx_w),
    .addr_o (addr_w),
    .last_o (last_w),
    .empty_o(empty_w)
  );

  qsd_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_w),
    .empty_i    (empty_w),
    .last_i     (last_w),
    .rd_valid_i (mem_rd_valid),
    .rd_data_i  (mem_rd_data),
    .snk_ready_i(ep_ready),
    .rd_req_o   (mem_rd_en),
    .snk_valid_o(ep_valid),
    .snk_data_o (ep_data),
    .accept_o   (accept_w),
    .finish_o   (finish_w)
  );

  assign mem_rd_addr  = addr_w;
  assign ep_last      = ep_valid && last_w;
  assign beat_ev      = accept_w;
  assign beat_ev_idx  = idx_w;
  assign beat_ev_addr = addr_w;
  assign done_ev      = finish_w;
  assign irq_done     = finish_w;
  assign chan_busy    = run_w;

endmodule

// File: rtl/qsd_chk.sv
module qsd_chk #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int DATA_W     = 128,
  parameter int CFG_W      = 32,
  parameter int BEAT_SHIFT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_en,
  input logic [7:0]        cfg_offset,
  input logic [CFG_W-1:0]  cfg_wr_data,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_rd_valid,
  input logic              ep_valid,
  input logic [DATA_W-1:0] ep_data,
  input logic              ep_last,
  input logic              ep_ready,
  input logic              beat_ev,
  input logic [CNT_W-1:0]  beat_ev_idx,
  input logic              done_ev,
  input logic              irq_done,
  input logic              chan_busy
);
  // Shadow of the programming, rebuilt from the port traffic.
  logic [ADDR_W-1:0] src_sh;
  logic [CNT_W-1:0]  len_sh;
  logic [CNT_W-1:0]  acc_q;
  logic              outst_q;
  logic              go;
  logic [ADDR_W-1:0] exp_addr;

  assign go = cfg_wr_en && !chan_busy && (cfg_offset == 8'h00) && cfg_wr_data[0];
  assign exp_addr = src_sh + (ADDR_W'(acc_q) << BEAT_SHIFT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_sh <= '0;
      len_sh <= '0;
    end else if (cfg_wr_en && !chan_busy) begin
      if (cfg_offset == 8'h10) src_sh <= ADDR_W'(cfg_wr_data);
      if (cfg_offset == 8'h20) len_sh <= CNT_W'(cfg_wr_data);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     acc_q <= '0;
    else if (go)                    acc_q <= '0;
    else if (ep_valid && ep_ready)  acc_q <= acc_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            outst_q <= 1'b0;
    else if (mem_rd_en)    outst_q <= 1'b1;
    else if (mem_rd_valid) outst_q <= 1'b0;
  end

  assert_rd_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> mem_rd_addr == exp_addr);

  assert_single_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !outst_q);

  assert_valid_after_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ep_valid) |-> $past(mem_rd_valid));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ep_valid && !ep_ready |=> ep_valid && $stable(ep_data) && $stable(ep_last));

  assert_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ep_valid |-> ep_last == (acc_q == CNT_W'(len_sh - 1'b1)));

  assert_beat_idx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_ev |-> beat_ev_idx == acc_q);

  assert_done_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |-> irq_done && acc_q == len_sh);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> !done_ev);

  assert_busy_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> !chan_busy);

  assert_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    go && len_sh == '0 |=> done_ev);

endmodule

bind qw_stream_dma qsd_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .CFG_W(CFG_W),
  .BEAT_SHIFT(BEAT_SHIFT)
) u_qsd_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_offset  (cfg_offset),
  .cfg_wr_data (cfg_wr_data),
  .mem_rd_en   (mem_rd_en),
  .mem_rd_addr (mem_rd_addr),
  .mem_rd_valid(mem_rd_valid),
  .ep_valid    (ep_valid),
  .ep_data     (ep_data),
  .ep_last     (ep_last),
  .ep_ready    (ep_ready),
  .beat_ev     (beat_ev),
  .beat_ev_idx (beat_ev_idx),
  .done_ev     (done_ev),
  .irq_done    (irq_done),
  .chan_busy   (chan_busy)
);

// File: tb/qw_stream_dma_test.sv
`timescale 1ns/1ps
module qw_stream_dma_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] base;
    logic [15:0] len;
    logic [3:0]  lat;
    logic [15:0] pat;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0300, 16'd4, 4'd1, 16'hFFFF},
    '{32'h0000_1000, 16'd5, 4'd3, 16'hA5A5},
    '{32'h0000_0040, 16'd1, 4'd2, 16'h0F0F},
    '{32'hFFFF_FFE0, 16'd3, 4'd1, 16'h8001},
    '{32'h0000_0200, 16'd6, 4'd5, 16'hCCCC}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cfg_wr_en;
  logic [7:0]   cfg_offset;
  logic [31:0]  cfg_wr_data;
  logic         mem_rd_en;
  logic [31:0]  mem_rd_addr;
  logic [127:0] mem_rd_data;
  logic         mem_rd_valid;
  logic         ep_valid;
  logic [127:0] ep_data;
  logic         ep_last;
  logic         ep_ready;
  logic         beat_ev;
  logic [15:0]  beat_ev_idx;
  logic [31:0]  beat_ev_addr;
  logic         done_ev;
  logic         irq_done;
  logic         chan_busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  qw_stream_dma uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_offset(cfg_offset), .cfg_wr_data(cfg_wr_data),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .mem_rd_valid(mem_rd_valid),
    .ep_valid(ep_valid), .ep_data(ep_data), .ep_last(ep_last), .ep_ready(ep_ready),
    .beat_ev(beat_ev), .beat_ev_idx(beat_ev_idx), .beat_ev_addr(beat_ev_addr),
    .done_ev(done_ev), .irq_done(irq_done), .chan_busy(chan_busy)
  );

  int n_chk = 0;
  int n_fail = 0;

  // Environment state shared with the tests.
  logic [31:0] exp_base = 32'd0;
  int          exp_n = 0;
  int          beat_k = 0;
  int          done_cnt = 0;
  int          rd_cnt = 0;
  int          lat = 1;
  logic [15:0] pat = 16'hFFFF;
  bit          force_stall = 1'b0;

  task automatic chk(input bit ok, input string tag,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] mem_word(input logic [31:0] a);
    return {a ^ 32'hC3C3_0000, ~a, a * 32'd7, {a[15:0], a[31:16]}};
  endfunction

  function automatic logic [31:0] addr_of(input logic [31:0] b, input int k);
    return b + (32'(k) * 32'd16);
  endfunction

  // Memory model, sink and monitor: one process on the falling edge.
  initial begin
    bit          pend = 1'b0;
    int          pcnt = 0;
    logic [31:0] paddr = '0;
    int          cyc = 0;
    bit          hold_prev = 1'b0;
    logic [127:0] prev_data = '0;
    logic        prev_last = 1'b0;
    mem_rd_valid = 1'b0;
    mem_rd_data  = '0;
    ep_ready     = 1'b0;
    forever begin
      @(negedge clk);
      mem_rd_valid = 1'b0;
      if (pend) begin
        pcnt--;
        if (pcnt <= 0) begin
          mem_rd_valid = 1'b1;
          mem_rd_data  = mem_word(paddr);
          pend = 1'b0;
        end
      end
      ep_ready = !force_stall && pat[4'(cyc)];
      cyc++;
      #1;
      if (rst_n) begin
        if (hold_prev)
          chk(ep_valid && ep_data == prev_data && ep_last == prev_last,
              "R5 word held under stall", ep_data, prev_data);
        hold_prev = ep_valid && !ep_ready;
        prev_data = ep_data;
        prev_last = ep_last;
        if (beat_ev != (ep_valid && ep_ready))
          chk(1'b0, "R7 beat event vs handshake", 128'(beat_ev), 128'(ep_valid && ep_ready));
        if (ep_valid && ep_ready) begin
          chk(ep_data == mem_word(addr_of(exp_base, beat_k)), "R4 stream data",
              ep_data, mem_word(addr_of(exp_base, beat_k)));
          chk(ep_last == (beat_k == exp_n - 1), "R6 last marker",
              128'(ep_last), 128'(beat_k == exp_n - 1));
          chk(beat_ev && beat_ev_idx == 16'(beat_k), "R7 beat index",
              128'(beat_ev_idx), 128'(beat_k));
          chk(beat_ev_addr == addr_of(exp_base, beat_k), "R7 beat address",
              128'(beat_ev_addr), 128'(addr_of(exp_base, beat_k)));
          beat_k++;
        end
        if (done_ev) begin
          chk(irq_done, "R8 interrupt with done", 128'(irq_done), 128'(1));
          chk(beat_k == exp_n, "R8 done after all beats", 128'(beat_k), 128'(exp_n));
          done_cnt++;
        end
        if (mem_rd_en) begin
          chk(!pend && !ep_valid, "R3 single outstanding read", 128'(pend), 128'(0));
          chk(mem_rd_addr == addr_of(exp_base, beat_k), "R3 read address",
              128'(mem_rd_addr), 128'(addr_of(exp_base, beat_k)));
          rd_cnt++;
          pend  = 1'b1;
          pcnt  = lat;
          paddr = mem_rd_addr;
        end
      end else begin
        hold_prev = 1'b0;
        pend = 1'b0;
      end
    end
  end

  task automatic cfg_write(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en   = 1'b1;
    cfg_offset  = off;
    cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en   = 1'b0;
    cfg_offset  = 8'h00;
    cfg_wr_data = 32'd0;
  endtask

  task automatic wait_done(input int d0, input int limit, output int spent);
    spent = 0;
    while (done_cnt == d0 && spent < limit) begin
      @(negedge clk);
      #2;
      spent++;
    end
  endtask

  task automatic finish_checks(input int d0, input string tag);
    chk(done_cnt == d0 + 1, tag, 128'(done_cnt - d0), 128'(1));
    chk(beat_k == exp_n, "R7 total beats", 128'(beat_k), 128'(exp_n));
    @(negedge clk);
    #2;
    chk(!chan_busy, "R9 run flag cleared", 128'(chan_busy), 128'(0));
  endtask

  initial begin
    int d0;
    int spent;
    int r0;
    rst_n = 1'b0;
    cfg_wr_en = 1'b0;
    cfg_offset = 8'h00;
    cfg_wr_data = 32'd0;

    // R1: outputs quiet during reset
    repeat (3) @(negedge clk);
    #2;
    chk(!ep_valid && !mem_rd_en && !beat_ev && !done_ev && !irq_done && !chan_busy,
        "R1 reset state",
        128'({ep_valid, mem_rd_en, beat_ev, done_ev, irq_done, chan_busy}), 128'(0));
    @(negedge clk);
    rst_n = 1'b1;

    // Vector table: R2 programming with several latencies and ready patterns
    for (int v = 0; v < NV; v++) begin
      exp_base = VECS[v].base;
      exp_n    = int'(VECS[v].len);
      lat      = int'(VECS[v].lat);
      pat      = VECS[v].pat;
      beat_k   = 0;
      cfg_write(8'h10, VECS[v].base);
      cfg_write(8'h20, 32'(VECS[v].len));
      d0 = done_cnt;
      cfg_write(8'h00, 32'h1);
      #2;
      chk(chan_busy, "R2 start sets run flag", 128'(chan_busy), 128'(1));
      wait_done(d0, 2000, spent);
      finish_checks(d0, "R2 transfer completes");
    end

    // R2: control write with bit 0 clear starts nothing
    pat = 16'hFFFF;
    lat = 1;
    r0 = rd_cnt;
    cfg_write(8'h00, 32'hFFFF_FFFE);
    repeat (8) @(negedge clk);
    #2;
    chk(rd_cnt == r0 && !chan_busy, "R2 bit0 clear ignored",
        128'(rd_cnt - r0), 128'(0));

    // R5/R8: long stall after two accepted beats
    exp_base = 32'h0000_0700;
    exp_n    = 4;
    beat_k   = 0;
    cfg_write(8'h10, exp_base);
    cfg_write(8'h20, 32'd4);
    d0 = done_cnt;
    cfg_write(8'h00, 32'h1);
    spent = 0;
    while (beat_k < 2 && spent < 200) begin
      @(negedge clk);
      #2;
      spent++;
    end
    force_stall = 1'b1;
    repeat (30) @(negedge clk);
    #2;
    chk(beat_k == 2, "R5 no beat during stall", 128'(beat_k), 128'(2));
    chk(done_cnt == d0, "R8 no done during stall", 128'(done_cnt - d0), 128'(0));
    chk(ep_valid && !ep_last, "R5 beat 2 offered and held", 128'({ep_valid, ep_last}), 128'(2));
    force_stall = 1'b0;
    wait_done(d0, 500, spent);
    finish_checks(d0, "R8 completes after stall");

    // R9: writes during a transfer are ignored
    exp_base = 32'h0000_0500;
    exp_n    = 3;
    lat      = 2;
    beat_k   = 0;
    cfg_write(8'h10, exp_base);
    cfg_write(8'h20, 32'd3);
    d0 = done_cnt;
    cfg_write(8'h00, 32'h1);
    cfg_write(8'h10, 32'h0000_9000);
    cfg_write(8'h20, 32'd7);
    cfg_write(8'h00, 32'h1);
    wait_done(d0, 500, spent);
    finish_checks(d0, "R9 first run completes");
    beat_k = 0;
    d0 = done_cnt;
    cfg_write(8'h00, 32'h1);
    wait_done(d0, 500, spent);
    finish_checks(d0, "R9 restart reuses programming");

    // R10: zero count completes at once
    exp_n  = 0;
    beat_k = 0;
    r0 = rd_cnt;
    cfg_write(8'h20, 32'd0);
    d0 = done_cnt;
    cfg_write(8'h00, 32'h1);
    #2;
    chk(done_ev, "R10 done the cycle after start", 128'(done_ev), 128'(1));
    wait_done(d0, 4, spent);
    chk(rd_cnt == r0, "R10 no reads", 128'(rd_cnt - r0), 128'(0));
    finish_checks(d0, "R10 zero-count done once");

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R8: actual no completion expected run to end");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule